// File: doc/BRIEF.md
# Converter Calibration Sequence Controller

This block sequences the calibration of a sigma-delta converter. Software starts a calibration by writing a nonzero code into the 2-bit mode field. The controller then counts output-rate periods, marked by a one-cycle `rate_tick` pulse. It raises a zero-scale or full-scale step strobe for each period of the calibration, so that coefficient capture elsewhere can be triggered. No coefficient arithmetic is done here.

The sequence ends in two stages, with different timing:

- **First stage.** When the calibration periods are done, the mode field returns to 00. This tells software that calibration is over. It does not mean that a new sample exists.
- **Second stage.** One normal conversion then runs, followed by a fixed pipeline delay counted in system clocks. Only after that does the active-low data-ready output fall. That fall signals that the first correctly scaled result is available.

`busy` covers the whole sequence, from the start write to the data-ready fall. There is no data stream through the block, so every pin is a plain control or status pin and none uses a handshake.

Top module: `cal_seq_ctrl`

## Requirements
- R1: After reset, `mode_bits` is 00, `busy` is 0, `drdy_n` is 1 and both `zs_step` and `fs_step` are 0.
- R2: When `busy` is 0, a write (`mode_we`=1) of a nonzero code starts a sequence. From the following cycle, `mode_bits` equals the code, `busy` is 1 and `drdy_n` is 1. The codes are:
  - 01: self-calibration.
  - 10: system zero-scale calibration.
  - 11: system full-scale calibration.
- R3: A write of code 00 while idle has no effect. Any write while `busy` is 1 also has no effect. In both cases `mode_bits`, `busy` and the sequence timing are unchanged.
- R4: For code 01, `mode_bits` stays 01 until the clock edge that samples the 6th `rate_tick` after the start. It reads 00 from that edge on.
- R5: For code 10 or 11, `mode_bits` holds the code until the edge that samples the 3rd `rate_tick`. It reads 00 from that edge on.
- R6: `drdy_n` falls exactly `PIPE_CLKS` clock edges after the edge that samples the final tick of the sequence. The final tick is the 9th for code 01 and the 4th for code 10 or 11. `busy` falls on the same edge, and `drdy_n` then stays 0 until the next start.
- R7: For code 01, `zs_step` is 1 during periods 1 to 3 and `fs_step` is 1 during periods 4 to 6. For code 10, `zs_step` is 1 during periods 1 to 3. For code 11, `fs_step` is 1 during periods 1 to 3. Both strobes are 0 at all other times and are never 1 together.
- R8: A `rate_tick` that arrives while idle, or during the pipeline delay, is ignored.
- R9: `PIPE_CLKS` is a parameter (default 2000). Elaboration fails unless 1 ≤ `PIPE_CLKS` ≤ 2000.
- R10: `busy` stays 1 and `drdy_n` stays 1 from the start until the data-ready fall. This includes the interval after `mode_bits` has returned to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_tick | input | 1 | One-cycle pulse marking the end of an output-rate period |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_wcode | input | 2 | Code written into the mode field |
| mode_bits | output | 2 | Current mode field; returns to 00 when calibration ends |
| busy | output | 1 | Sequence in progress, from start to data-ready fall |
| zs_step | output | 1 | Zero-scale calibration period active |
| fs_step | output | 1 | Full-scale calibration period active |
| drdy_n | output | 1 | Data-ready, active low |

## Verification
The bench builds the block with `PIPE_CLKS` = 7 and leaves the period counts at their defaults. With the short delay, every sequence reaches the data-ready fall in a few dozen cycles. This lets the bench run all three calibration codes, each with a different tick spacing (back-to-back ticks as well as sparse ones). It also inserts ticks inside the pipeline window and writes that arrive while busy. A scoreboard predicts the exact edge of each start, each mode clear and each data-ready fall, so an off-by-one in either stage shows up as a cycle mismatch.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    CAL_NORMAL = 2'b00,
    CAL_SELF   = 2'b01,
    CAL_SYS_ZS = 2'b10,
    CAL_SYS_FS = 2'b11
  } cal_code_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CAL,
    PH_CONV,
    PH_PIPE
  } cal_phase_e;

  localparam int unsigned PIPE_CLKS_MAX = 2000;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cal_tick_counter.sv
module cal_tick_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cal_pipe_timer.sv
module cal_pipe_timer #(
  parameter int unsigned PIPE_CLKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  localparam int unsigned TW = (PIPE_CLKS > 1) ? $clog2(PIPE_CLKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(PIPE_CLKS - 1);

  logic          run_q;
  logic [TW-1:0] cnt_q;

  assign done = run_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cal_step_decode.sv
module cal_step_decode
  import cal_seq_pkg::*;
#(
  parameter int unsigned CNT_W           = 4,
  parameter int unsigned SELF_ZS_PERIODS = 3
) (
  input  cal_phase_e       phase,
  input  cal_code_e        kind,
  input  logic [CNT_W-1:0] cnt,
  output logic             zs_step,
  output logic             fs_step
);

  localparam logic [CNT_W-1:0] ZS_SPLIT = CNT_W'(SELF_ZS_PERIODS);

  always_comb begin
    zs_step = 1'b0;
    fs_step = 1'b0;
    if (phase == PH_CAL) begin
      unique case (kind)
        CAL_SELF: begin
          zs_step = (cnt < ZS_SPLIT);
          fs_step = !(cnt < ZS_SPLIT);
        end
        CAL_SYS_ZS: zs_step = 1'b1;
        CAL_SYS_FS: fs_step = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
#(
  parameter int unsigned SELF_CAL_PERIODS = 6,
  parameter int unsigned SELF_ZS_PERIODS  = 3,
  parameter int unsigned SYS_CAL_PERIODS  = 3,
  parameter int unsigned SELF_RDY_PERIODS = 9,
  parameter int unsigned SYS_RDY_PERIODS  = 4,
  parameter int unsigned PIPE_CLKS        = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_tick,
  input  logic       mode_we,
  input  logic [1:0] mode_wcode,
  output logic [1:0] mode_bits,
  output logic       busy,
  output logic       zs_step,
  output logic       fs_step,
  output logic       drdy_n
);

  localparam int unsigned MAX_PERIODS = max_u(SELF_RDY_PERIODS, SYS_RDY_PERIODS);
  localparam int unsigned CNT_W       = $clog2(MAX_PERIODS + 1);

  // R9: elaboration-time range checks
  generate
    if (PIPE_CLKS < 1 || PIPE_CLKS > PIPE_CLKS_MAX) begin : g_bad_pipe
      $error("cal_seq_ctrl: PIPE_CLKS out of range 1..2000");
    end
    if (SELF_ZS_PERIODS < 1 || SELF_ZS_PERIODS >= SELF_CAL_PERIODS) begin : g_bad_split
      $error("cal_seq_ctrl: SELF_ZS_PERIODS must lie inside the self-calibration");
    end
    if (SELF_RDY_PERIODS <= SELF_CAL_PERIODS || SYS_RDY_PERIODS <= SYS_CAL_PERIODS) begin : g_bad_rdy
      $error("cal_seq_ctrl: data-ready period count must exceed calibration count");
    end
  endgenerate

  cal_phase_e       phase_q;
  cal_code_e        kind_q;
  logic [1:0]       mode_q;
  logic             drdy_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cal_end;
  logic [CNT_W-1:0] rdy_end;
  logic             start;
  logic             counting;
  logic             cal_last;
  logic             rdy_last;
  logic             pipe_done;

  assign start    = (phase_q == PH_IDLE) && mode_we && (mode_wcode != CAL_NORMAL);
  assign counting = rate_tick && ((phase_q == PH_CAL) || (phase_q == PH_CONV));
  assign cnt_inc  = cnt + 1'b1;

  always_comb begin
    if (kind_q == CAL_SELF) begin
      cal_end = CNT_W'(SELF_CAL_PERIODS);
      rdy_end = CNT_W'(SELF_RDY_PERIODS);
    end else begin
      cal_end = CNT_W'(SYS_CAL_PERIODS);
      rdy_end = CNT_W'(SYS_RDY_PERIODS);
    end
  end

  assign cal_last = (phase_q == PH_CAL)  && rate_tick && (cnt_inc == cal_end);
  assign rdy_last = (phase_q == PH_CONV) && rate_tick && (cnt_inc == rdy_end);

  cal_tick_counter #(
    .CNT_W (CNT_W)
  ) u_ticks (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .inc   (counting),
    .cnt   (cnt)
  );

  cal_pipe_timer #(
    .PIPE_CLKS (PIPE_CLKS)
  ) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rdy_last),
    .done  (pipe_done)
  );

  cal_step_decode #(
    .CNT_W           (CNT_W),
    .SELF_ZS_PERIODS (SELF_ZS_PERIODS)
  ) u_steps (
    .phase   (phase_q),
    .kind    (kind_q),
    .cnt     (cnt),
    .zs_step (zs_step),
    .fs_step (fs_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= CAL_NORMAL;
      mode_q  <= 2'b00;
      drdy_q  <= 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_CAL;
            kind_q  <= cal_code_e'(mode_wcode);
            mode_q  <= mode_wcode;
            drdy_q  <= 1'b1;
          end
        end
        PH_CAL: begin
          if (cal_last) begin
            phase_q <= PH_CONV;
            mode_q  <= 2'b00;
          end
        end
        PH_CONV: begin
          if (rdy_last) phase_q <= PH_PIPE;
        end
        PH_PIPE: begin
          if (pipe_done) begin
            phase_q <= PH_IDLE;
            drdy_q  <= 1'b0;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign mode_bits = mode_q;
  assign busy      = (phase_q != PH_IDLE);
  assign drdy_n    = drdy_q;

endmodule

// File: rtl/cal_seq_ctrl_chk.sv
module cal_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rate_tick,
  input logic       mode_we,
  input logic [1:0] mode_wcode,
  input logic [1:0] mode_bits,
  input logic       busy,
  input logic       zs_step,
  input logic       fs_step,
  input logic       drdy_n
);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode_we && mode_wcode != 2'b00) |=>
      (busy && drdy_n && mode_bits == $past(mode_wcode)));

  assert_idle_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(mode_we && mode_wcode != 2'b00)) |=> (!busy && mode_bits == 2'b00));

  assert_busy_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_we && !rate_tick) |=> (mode_bits == $past(mode_bits)));

  assert_no_mode_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mode_bits == 2'b00));

  assert_drdy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> (!busy && mode_bits == 2'b00 && $past(busy)));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(zs_step && fs_step));

  assert_strobe_in_cal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zs_step || fs_step) |-> (busy && mode_bits != 2'b00));

  assert_drdy_high_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> drdy_n);

endmodule

bind cal_seq_ctrl cal_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rate_tick  (rate_tick),
  .mode_we    (mode_we),
  .mode_wcode (mode_wcode),
  .mode_bits  (mode_bits),
  .busy       (busy),
  .zs_step    (zs_step),
  .fs_step    (fs_step),
  .drdy_n     (drdy_n)
);

// File: tb/cal_seq_ctrl_bench.sv
module cal_seq_ctrl_bench;

  localparam int PIPE = 7;
  localparam int EV_START = 0;
  localparam int EV_CLEAR = 1;
  localparam int EV_RDY   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_tick = 1'b0;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wcode = 2'b00;
  logic [1:0] mode_bits;
  logic       busy, zs_step, fs_step, drdy_n;

  int tests = 0;
  int fails = 0;
  int edge_n = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;
    int    at_edge;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) edge_n <= edge_n + 1;

  cal_seq_ctrl #(
    .PIPE_CLKS (PIPE)
  ) u_cal_seq_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_tick  (rate_tick),
    .mode_we    (mode_we),
    .mode_wcode (mode_wcode),
    .mode_bits  (mode_bits),
    .busy       (busy),
    .zs_step    (zs_step),
    .fs_step    (fs_step),
    .drdy_n     (drdy_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push_exp(input int kind, input int at, input string req);
    exp_t e;
    e.kind = kind;
    e.at_edge = at;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: observe events at the negedge and compare with the scoreboard
  logic [1:0] prev_mode = 2'b00;
  logic       prev_drdy = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      int kind;
      kind = -1;
      if (prev_mode == 2'b00 && mode_bits != 2'b00) kind = EV_START;
      else if (prev_mode != 2'b00 && mode_bits == 2'b00) kind = EV_CLEAR;
      if (kind >= 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected mode event", kind, -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.kind == kind, e.req, kind, e.kind);
          chk(e.at_edge == edge_n, e.req, edge_n, e.at_edge);
        end
      end
      if (prev_drdy && !drdy_n) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected data-ready", EV_RDY, -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.kind == EV_RDY, e.req, EV_RDY, e.kind);
          chk(e.at_edge == edge_n, e.req, edge_n, e.at_edge);
        end
      end
      prev_mode = mode_bits;
      prev_drdy = drdy_n;
    end
  end

  // Driver: runs one calibration and records the expected event edges
  task automatic run_cal(input logic [1:0] code, input int gap,
                         input bit poke_busy, input bit tick_in_pipe);
    int cal_end;
    int rdy_end;
    string clr_req;
    cal_end = (code == 2'b01) ? 6 : 3;
    rdy_end = (code == 2'b01) ? 9 : 4;
    clr_req = (code == 2'b01) ? "R4 mode clear" : "R5 mode clear";
    @(negedge clk);
    rate_tick = 1'b0;
    mode_we = 1'b1;
    mode_wcode = code;
    push_exp(EV_START, edge_n + 1, "R2 start");
    @(negedge clk);
    mode_we = 1'b0;
    chk(mode_bits == code, "R2 mode after write", mode_bits, code);
    chk(busy && drdy_n, "R2 busy/drdy_n after start", {busy, drdy_n}, 3);
    for (int p = 1; p <= rdy_end; p++) begin
      if (gap > 0) begin
        rate_tick = 1'b0;
        repeat (gap) @(negedge clk);
      end
      if (poke_busy && p == 2) begin
        rate_tick = 1'b0;
        mode_we = 1'b1;
        mode_wcode = (code == 2'b11) ? 2'b01 : 2'b11;
        @(negedge clk);
        mode_we = 1'b0;
        chk(mode_bits == code && busy, "R3 write while busy", mode_bits, code);
      end
      begin
        bit ez;
        bit ef;
        ez = (p <= cal_end) && ((code == 2'b10) || (code == 2'b01 && p <= 3));
        ef = (p <= cal_end) && ((code == 2'b11) || (code == 2'b01 && p > 3));
        chk(zs_step == ez && fs_step == ef, "R7 step strobes",
            {zs_step, fs_step}, {ez, ef});
        if (p <= cal_end) chk(mode_bits == code, clr_req, mode_bits, code);
        else chk(mode_bits == 2'b00 && busy && drdy_n, "R10 busy after clear",
                 {mode_bits, busy, drdy_n}, 3);
      end
      rate_tick = 1'b1;
      if (p == cal_end) push_exp(EV_CLEAR, edge_n + 1, clr_req);
      if (p == rdy_end) push_exp(EV_RDY, edge_n + 1 + PIPE, "R6 data-ready timing");
      @(negedge clk);
    end
    rate_tick = 1'b0;
    chk(busy && drdy_n && mode_bits == 2'b00, "R10 busy in pipeline delay",
        {busy, drdy_n}, 3);
    for (int c = 0; c < PIPE + 3; c++) begin
      rate_tick = tick_in_pipe && (c % 2 == 0);  // R8: ignored ticks
      @(negedge clk);
    end
    rate_tick = 1'b0;
    chk(!busy && !drdy_n, "R6 idle with data ready", {busy, drdy_n}, 0);
    chk(!zs_step && !fs_step, "R7 no strobe after sequence", {zs_step, fs_step}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mode_bits == 2'b00 && !busy, "R1 reset mode/busy", {mode_bits, busy}, 0);
    chk(drdy_n && !zs_step && !fs_step, "R1 reset drdy/strobes",
        {drdy_n, zs_step, fs_step}, 4);

    // R8 idle ticks do nothing
    for (int i = 0; i < 5; i++) begin
      rate_tick = 1'b1;
      @(negedge clk);
    end
    rate_tick = 1'b0;
    chk(!busy && mode_bits == 2'b00 && drdy_n, "R8 idle ticks ignored",
        {busy, mode_bits}, 0);

    // R3 write of 00 while idle
    mode_we = 1'b1;
    mode_wcode = 2'b00;
    @(negedge clk);
    mode_we = 1'b0;
    @(negedge clk);
    chk(!busy && mode_bits == 2'b00, "R3 idle write 00", {busy, mode_bits}, 0);

    run_cal(2'b01, 2, 1'b0, 1'b0);  // self-calibration, sparse ticks
    run_cal(2'b10, 0, 1'b1, 1'b1);  // system zero-scale, back-to-back ticks
    run_cal(2'b11, 3, 1'b1, 1'b1);  // system full-scale
    run_cal(2'b01, 1, 1'b1, 1'b1);  // self again from data-ready low

    // R3 write of 00 while idle leaves data-ready low
    mode_we = 1'b1;
    mode_wcode = 2'b00;
    @(negedge clk);
    mode_we = 1'b0;
    @(negedge clk);
    chk(!busy && !drdy_n && mode_bits == 2'b00, "R3 idle write 00 after data",
        {busy, drdy_n}, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule